// File: doc/BRIEF.md
# Two-Class Trap Arbitration Controller

This block sits next to a pipelined CPU and turns trap events into one dispatch request at a time. Traps come in two classes. Recoverable traps include an asynchronous non-maskable interrupt and three events that the pipeline reports from its memory stage. Failure traps signal unrecoverable hardware faults. Every event sets a sticky flag. Software clears a flag by writing a one to it. The controller then chooses which pending trap to serve. It flushes the pipeline and issues a push strobe that carries the address of the first instruction that has not executed, together with a vector index.

Recoverable traps wait while an atomic or extend sequence, or an I/O read, is still running. Failure traps pre-empt at once, even in the middle of such a sequence or of a recoverable service routine. When a service routine returns, the controller looks at the flags again. A recoverable flag that is still set is dispatched straight away, and the same return address is pushed again.

Top module: `trap_arbiter`

## Requirements
- R1: After reset, all flags are 0 and push_o and flush_o are low.
- R2: A pipeline event on rec_evt_i sets its flag only in a cycle where mem_stage_i is high. Otherwise it is ignored.
- R3: A rising edge on nmi_i sets flag bit 0 after a two-flop synchronizer. A level held high sets the flag only once.
- R4: Flags stay set until a cycle in which clr_we_i is high and the matching clr_mask_i bit is 1. If a set and a clear reach the same bit in the same cycle, the flag stays set. With clr_we_i low, clr_mask_i has no effect.
- R5: A dispatch pulses push_o and flush_o high for one cycle, and push_addr_o carries next_pc_i. The flag layout is: bit 0 NMI, bit 1 stack overflow, bit 2 stack underflow, bit 3 software break, bits 4 and up failure sources. The three rec_evt_i bits, from LSB upward, map to flag bits 1 to 3. A recoverable dispatch reports vec_o = 1 + flag bit index.
- R6: No recoverable dispatch happens while seq_busy_i or io_rd_busy_i is high. A pending recoverable trap is dispatched once both inputs are low.
- R7: A failure trap dispatches with vec_o = 0 even while a sequence is busy or a recoverable service is active.
- R8: When failure and recoverable flags are both pending, the failure trap is dispatched first.
- R9: While a recoverable service is active, no further recoverable dispatch happens until trap_ret_i.
- R10: On trap_ret_i, a recoverable flag that is still set is dispatched in the next cycle with the current next_pc_i. If every flag has been cleared, nothing is dispatched.
- R11: Several recoverable events in one cycle set all of their flags. Only the one with the lowest flag bit is dispatched.
- R12: Several failure events in one cycle set all of their flags and cause a single dispatch with vector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_i | input | 1 | Asynchronous non-maskable interrupt |
| mem_stage_i | input | 1 | The pipeline event qualifier: high when the instruction is in the memory stage |
| rec_evt_i | input | 3 | Recoverable pipeline event pulses: stack overflow, stack underflow, software break |
| fail_evt_i | input | NUM_FAIL | Failure event pulses |
| seq_busy_i | input | 1 | Atomic or extend sequence in progress |
| io_rd_busy_i | input | 1 | I/O read access in progress |
| next_pc_i | input | ADDR_W | Address of the first instruction not yet executed |
| trap_ret_i | input | 1 | Return-from-trap strobe |
| clr_we_i | input | 1 | Flag clear write enable |
| clr_mask_i | input | 4+NUM_FAIL | Write-one-to-clear mask |
| flags_o | output | 4+NUM_FAIL | Sticky trap flags |
| flush_o | output | 1 | Pipeline flush pulse |
| push_o | output | 1 | Push strobe for the return address |
| push_addr_o | output | ADDR_W | Address to push |
| vec_o | output | 3 | Vector index of the dispatch |

## Verification
The assertions check, on every cycle, that each dispatch follows a flag that was set in the cycle before. They also check that a recoverable dispatch never follows a busy cycle or a pending failure flag, that no two recoverable dispatches occur back to back without a return, and that a flag never drops without a clear write. Only the bench scenarios can show the order of chained dispatches after a return, and that a held NMI level is not re-armed. The same holds for the set-over-clear outcome, for ignored off-stage events, and for the pushed addresses and vectors seen against the expected sequence.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int NUM_A   = 4;
    localparam int VEC_W   = $clog2(NUM_A + 1);
    localparam int NMI_BIT = 0;

    typedef enum logic [1:0] {
        SVC_IDLE,
        SVC_REC,
        SVC_FAIL
    } svc_state_e;

    typedef struct packed {
        logic             hit;
        logic [VEC_W-1:0] vec;
    } pick_t;

    // Lowest flag bit wins; vector is bit index plus one.
    function automatic pick_t pick_rec(input logic [NUM_A-1:0] pend);
        pick_t p;
        p.hit = 1'b0;
        p.vec = '0;
        for (int i = NUM_A - 1; i >= 0; i--) begin
            if (pend[i]) begin
                p.hit = 1'b1;
                p.vec = VEC_W'(i + 1);
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/trap_nmi_sync.sv
module trap_nmi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic nmi_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], nmi_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/trap_flag_reg.sv
module trap_flag_reg #(
    parameter int NF = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set_i,
    input  logic          clr_we_i,
    input  logic [NF-1:0] clr_mask_i,
    output logic [NF-1:0] flags_o
);
    for (genvar g = 0; g < NF; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (set_i[g]) begin
                bit_q <= 1'b1;
            end else if (clr_we_i && clr_mask_i[g]) begin
                bit_q <= 1'b0;
            end
        end
        assign flags_o[g] = bit_q;
    end
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
    import trap_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_FAIL = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_A-1:0]    rec_flags_i,
    input  logic [NUM_FAIL-1:0] fail_flags_i,
    input  logic                busy_i,
    input  logic                trap_ret_i,
    input  logic [ADDR_W-1:0]   next_pc_i,
    output logic                push_o,
    output logic [VEC_W-1:0]    vec_o,
    output logic [ADDR_W-1:0]   addr_o
);
    svc_state_e        state_q, state_n;
    pick_t             pick;
    logic              fail_pend, fire_fail, fire_rec, rec_free;
    logic              push_q;
    logic [VEC_W-1:0]  vec_q;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        pick      = pick_rec(rec_flags_i);
        fail_pend = |fail_flags_i;
        fire_fail = fail_pend && (state_q != SVC_FAIL || trap_ret_i);
        rec_free  = (state_q == SVC_IDLE) || trap_ret_i;
        fire_rec  = !fail_pend && pick.hit && rec_free && !busy_i;
        state_n   = state_q;
        if (trap_ret_i) state_n = SVC_IDLE;
        if (fire_fail)     state_n = SVC_FAIL;
        else if (fire_rec) state_n = SVC_REC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SVC_IDLE;
            push_q  <= 1'b0;
            vec_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_n;
            push_q  <= fire_fail || fire_rec;
            if (fire_fail || fire_rec) begin
                vec_q  <= fire_fail ? '0 : pick.vec;
                addr_q <= next_pc_i;
            end
        end
    end

    assign push_o = push_q;
    assign vec_o  = vec_q;
    assign addr_o = addr_q;
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_FAIL = 3,
    parameter int NF       = NUM_A + NUM_FAIL
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                nmi_i,
    input  logic                mem_stage_i,
    input  logic [NUM_A-2:0]    rec_evt_i,
    input  logic [NUM_FAIL-1:0] fail_evt_i,
    input  logic                seq_busy_i,
    input  logic                io_rd_busy_i,
    input  logic [ADDR_W-1:0]   next_pc_i,
    input  logic                trap_ret_i,
    input  logic                clr_we_i,
    input  logic [NF-1:0]       clr_mask_i,
    output logic [NF-1:0]       flags_o,
    output logic                flush_o,
    output logic                push_o,
    output logic [ADDR_W-1:0]   push_addr_o,
    output logic [VEC_W-1:0]    vec_o
);
    logic          nmi_rise;
    logic [NF-1:0] set_vec;

    trap_nmi_sync #(.STAGES(2)) i_nmi (
        .clk    (clk),
        .rst    (rst),
        .nmi_i  (nmi_i),
        .rise_o (nmi_rise)
    );

    assign set_vec = {fail_evt_i, rec_evt_i & {(NUM_A-1){mem_stage_i}}, nmi_rise};

    trap_flag_reg #(.NF(NF)) i_flags (
        .clk        (clk),
        .rst        (rst),
        .set_i      (set_vec),
        .clr_we_i   (clr_we_i),
        .clr_mask_i (clr_mask_i),
        .flags_o    (flags_o)
    );

    trap_dispatch #(.ADDR_W(ADDR_W), .NUM_FAIL(NUM_FAIL)) i_disp (
        .clk          (clk),
        .rst          (rst),
        .rec_flags_i  (flags_o[NUM_A-1:0]),
        .fail_flags_i (flags_o[NF-1:NUM_A]),
        .busy_i       (seq_busy_i | io_rd_busy_i),
        .trap_ret_i   (trap_ret_i),
        .next_pc_i    (next_pc_i),
        .push_o       (push_o),
        .vec_o        (vec_o),
        .addr_o       (push_addr_o)
    );

    assign flush_o = push_o;
endmodule

// File: rtl/trap_arbiter_chk.sv
module trap_arbiter_chk
    import trap_pkg::*;
#(
    parameter int NUM_FAIL = 3,
    parameter int NF       = NUM_A + NUM_FAIL
) (
    input logic             clk,
    input logic             rst,
    input logic             seq_busy_i,
    input logic             io_rd_busy_i,
    input logic             trap_ret_i,
    input logic             clr_we_i,
    input logic [NF-1:0]    clr_mask_i,
    input logic [NF-1:0]    flags_o,
    input logic             push_o,
    input logic [VEC_W-1:0] vec_o
);
    logic [NF-1:0] flags_q;
    always_ff @(posedge clk) flags_q <= flags_o;

    AST_REC_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        (push_o && vec_o != '0) |-> !$past(seq_busy_i) && !$past(io_rd_busy_i)); // R6

    AST_FAIL_BEFORE_REC: assert property (@(posedge clk) disable iff (rst)
        (push_o && vec_o != '0) |-> flags_q[NF-1:NUM_A] == '0); // R8

    AST_REC_VEC_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (push_o && vec_o != '0) |-> flags_q[32'(vec_o) - 1]); // R5

    AST_FAIL_VEC_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (push_o && vec_o == '0) |-> |flags_q[NF-1:NUM_A]); // R7

    AST_NO_REC_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (push_o && vec_o != '0 && !trap_ret_i) |=> !(push_o && vec_o != '0)); // R9

    for (genvar g = 0; g < NF; g++) begin : g_sticky
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            $fell(flags_o[g]) |-> $past(clr_we_i) && $past(clr_mask_i[g])); // R4
    end
endmodule

bind trap_arbiter trap_arbiter_chk #(.NUM_FAIL(NUM_FAIL)) i_chk (.*);

// File: tb/test_trap_arbiter.sv
module test_trap_arbiter;
    localparam int AW = 16;
    localparam int NB = 3;
    localparam int NF = 4 + NB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          nmi_i = 1'b0, mem_stage_i = 1'b0;
    logic [2:0]    rec_evt_i = '0;
    logic [NB-1:0] fail_evt_i = '0;
    logic          seq_busy_i = 1'b0, io_rd_busy_i = 1'b0;
    logic [AW-1:0] next_pc_i = 16'h1234;
    logic          trap_ret_i = 1'b0, clr_we_i = 1'b0;
    logic [NF-1:0] clr_mask_i = '0;
    logic [NF-1:0] flags_o;
    logic          flush_o, push_o;
    logic [AW-1:0] push_addr_o;
    logic [2:0]    vec_o;

    trap_arbiter #(.ADDR_W(AW), .NUM_FAIL(NB)) i_trap_arbiter (.*);

    always #10 clk = ~clk;

    typedef struct packed { logic [2:0] vec; logic [AW-1:0] addr; } exp_t;
    exp_t  exp_q[$];
    int    n_tests = 0, n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Monitor: compare each dispatch against the scoreboard.
    always @(negedge clk) begin
        if (!rst && push_o) begin
            if (exp_q.size() == 0) begin
                chk(cur_req, {29'd0, vec_o}, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(cur_req, {29'd0, vec_o}, {29'd0, e.vec});
                chk(cur_req, {16'd0, push_addr_o}, {16'd0, e.addr});
                chk(cur_req, {31'd0, flush_o}, 32'd1);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic expect_d(input logic [2:0] v);
        exp_q.push_back({v, next_pc_i});
    endtask
    task automatic pulse_rec(input logic [2:0] m, input logic stage);
        rec_evt_i = m; mem_stage_i = stage; tick(1);
        rec_evt_i = '0; mem_stage_i = 1'b0;
    endtask
    task automatic pulse_fail(input logic [NB-1:0] m);
        fail_evt_i = m; tick(1); fail_evt_i = '0;
    endtask
    task automatic clear(input logic [NF-1:0] m);
        clr_we_i = 1'b1; clr_mask_i = m; tick(1);
        clr_we_i = 1'b0; clr_mask_i = '0;
    endtask
    task automatic ret();
        trap_ret_i = 1'b1; tick(1); trap_ret_i = 1'b0;
    endtask
    task automatic drain();
        tick(6);
        chk({cur_req, " pending"}, exp_q.size(), 0);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1", flags_o, 0);
        chk("R1", push_o, 0);
        chk("R1", flush_o, 0);

        // R5 single stack overflow -> vector 2
        cur_req = "R5";
        expect_d(3'd2);
        pulse_rec(3'b001, 1'b1);
        tick(4);
        chk("R5", flags_o, 7'h02);
        clear(7'h02); ret(); drain();

        // R2 event outside memory stage ignored
        cur_req = "R2";
        pulse_rec(3'b111, 1'b0);
        tick(3);
        chk("R2", flags_o, 0);
        drain();

        // R11 two events together, R10 chained re-dispatch
        cur_req = "R11";
        next_pc_i = 16'h0400;
        expect_d(3'd3);
        pulse_rec(3'b110, 1'b1);
        tick(4);
        chk("R11", flags_o, 7'h0C);
        cur_req = "R10";
        expect_d(3'd4);
        clear(7'h04); ret();
        tick(3);
        chk("R10", exp_q.size(), 0);
        chk("R10", flags_o, 7'h08);
        clear(7'h08); ret(); drain();
        // R10 both cleared before return: no second dispatch
        expect_d(3'd3);
        pulse_rec(3'b110, 1'b1);
        tick(4);
        clear(7'h0C); ret(); drain();
        chk("R10", flags_o, 0);

        // R6 deferral on sequence and on I/O read
        cur_req = "R6";
        next_pc_i = 16'h0A10;
        seq_busy_i = 1'b1;
        pulse_rec(3'b100, 1'b1);
        tick(6);
        chk("R6", exp_q.size(), 0);
        expect_d(3'd4);
        seq_busy_i = 1'b0;
        tick(4);
        clear(7'h08); ret(); drain();
        io_rd_busy_i = 1'b1;
        pulse_rec(3'b001, 1'b1);
        tick(6);
        expect_d(3'd2);
        io_rd_busy_i = 1'b0;
        tick(4);
        clear(7'h02); ret(); drain();

        // R3 NMI held high: one flag set only
        cur_req = "R3";
        expect_d(3'd1);
        nmi_i = 1'b1;
        tick(8);
        chk("R3", flags_o, 7'h01);
        clear(7'h01); ret();
        tick(6);
        chk("R3", flags_o, 0);
        nmi_i = 1'b0;
        drain();

        // R7 failure pre-empts busy sequence and active service; R12 shared vector
        cur_req = "R7";
        next_pc_i = 16'h2222;
        expect_d(3'd4);
        pulse_rec(3'b100, 1'b1);
        tick(4);
        seq_busy_i = 1'b1;
        cur_req = "R12";
        expect_d(3'd0);
        pulse_fail(3'b101);
        tick(4);
        chk("R12", flags_o, 7'h58);
        chk("R7", exp_q.size(), 0);
        clear(7'h7F); ret();
        seq_busy_i = 1'b0;
        drain();

        // R8 failure before recoverable, then recoverable after return
        cur_req = "R8";
        expect_d(3'd0);
        expect_d(3'd3);
        rec_evt_i = 3'b010; mem_stage_i = 1'b1; fail_evt_i = 3'b010;
        tick(1);
        rec_evt_i = '0; mem_stage_i = 1'b0; fail_evt_i = '0;
        tick(4);
        chk("R8", flags_o, 7'h24);
        clear(7'h20); ret();
        tick(3);
        clear(7'h04); ret(); drain();

        // R4 set wins over clear, clear needs write enable
        cur_req = "R4";
        seq_busy_i = 1'b1;
        rec_evt_i = 3'b010; mem_stage_i = 1'b1; clr_we_i = 1'b1; clr_mask_i = 7'h04;
        tick(1);
        rec_evt_i = '0; mem_stage_i = 1'b0; clr_we_i = 1'b0; clr_mask_i = '0;
        tick(2);
        chk("R4", flags_o, 7'h04);
        clr_mask_i = 7'h04;
        tick(2);
        clr_mask_i = '0;
        chk("R4", flags_o, 7'h04);
        clear(7'h04);
        tick(1);
        chk("R4", flags_o, 0);
        seq_busy_i = 1'b0;
        drain();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule